// File: doc/BRIEF.md
# Key-Protected Vector Base Register

This block holds the 32-bit base address of the exception vector table and drives it straight to the exception logic. Software reaches it over a simple peripheral bus. The bus carries a word index, four byte enables, a write strobe, 32-bit write data and combinational 32-bit read data. Half-word accesses are made by enabling only lanes 1:0 or lanes 3:2. The base occupies word index 1: bits [15:0] are the low half-word (lanes 1:0) and bits [31:16] are the high half-word (lanes 3:2). A protect register sits at word index 0.

The base is guarded by a two-state lock machine:

- **SHUT** is the reset state. In SHUT, writes to the base are dropped.
- Writing the key byte 0x59 into lane 1 (bits [15:8]) of the protect register takes the machine through the **UNLOCK** transition to **OPEN**.
- In OPEN, writes to the base land lane by lane.
- Any base write that enables lane 3 (bits [31:24]) takes effect and then fires the **RELOCK** transition back to SHUT.
- Every other event keeps the current state. These are the **HOLD** self-loops.

Because of RELOCK, an update done in two half-word writes must write the low half first and the high half second. A single 32-bit write updates both halves and relocks in one access. Bits [9:0] of the base never store anything and always read zero, so the table stays aligned to 1 KB.

Top module: `vbase_guard`

## Requirements
- R1: After reset the base output and its read value are 0x00C00000, and the lock machine is in SHUT.
- R2: Bits [9:0] of the base always read and drive zero, whatever data is written.
- R3: In SHUT, a write to the base (word index 1) leaves the base unchanged.
- R4: A write to word index 0 with byte enable 1 set and write data bits [15:8] equal to 0x59 moves the machine to OPEN.
- R5: A write to word index 0 that does not put 0x59 into lane 1 leaves the lock state unchanged, in both SHUT and OPEN.
- R6: In OPEN, a base write with byte enable 3 clear updates the enabled lanes and keeps the machine in OPEN.
- R7: In OPEN, a base write with byte enable 3 set updates the enabled lanes and then returns the machine to SHUT.
- R8: In OPEN, a full word write (byte enables 4'b1111) updates all 32 bits in one access and relocks.
- R9: Reading word index 0 returns zero. Reading word index 1 returns the current base in both SHUT and OPEN.
- R10: A base write changes only the byte lanes whose enable is set.
- R11: Word indexes other than 0 and 1 read zero, and writes to them change neither the base nor the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (4) | Word index of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_be | input | 4 | Byte enables, bit n selects bits [8n+7:8n] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| vec_base | output | 32 | Vector table base to the exception logic |

## Verification
The assertions assume that bus_addr, bus_be and bus_wdata are known whenever bus_wr is high. They also assume that each write lasts one cycle, so a key write and a base write can never fall in the same cycle. The stimulus respects this: inputs change only on the falling edge, and each access drops the strobe after one rising edge. Random accesses cover every word index of the 4-bit space and all sixteen byte-enable patterns. Protect-register writes carry the key about half of the time, so the stimulus passes through SHUT and OPEN many times and in varied orders.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
    typedef enum logic {
        GUARD_SHUT = 1'b0,
        GUARD_OPEN = 1'b1
    } guard_state_t;

    localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/vbg_decode.sv
module vbg_decode #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned NLANES   = 4,
    parameter int unsigned PROT_IDX = 0,
    parameter int unsigned BASE_IDX = 1,
    parameter int unsigned KEY_LANE = 1,
    parameter logic [7:0]  KEY      = 8'h59
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr,
    input  logic [NLANES-1:0]     be,
    input  logic [NLANES*8-1:0]   wdata,
    output logic                  sel_base,
    output logic                  key_hit,
    output logic                  base_wr,
    output logic                  top_touch
);
    localparam int unsigned TOP_LANE = NLANES - 1;

    logic sel_prot;

    always_comb begin
        sel_prot  = (addr == ADDR_W'(PROT_IDX));
        sel_base  = (addr == ADDR_W'(BASE_IDX));
        key_hit   = wr && sel_prot && be[KEY_LANE]
                    && (wdata[KEY_LANE*8 +: 8] == KEY);
        base_wr   = wr && sel_base;
        top_touch = base_wr && be[TOP_LANE];
    end
endmodule

// File: rtl/vbg_lock_fsm.sv
module vbg_lock_fsm
    import vbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_hit,
    input  logic top_touch,
    output logic unlocked
);
    guard_state_t state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GUARD_SHUT: if (key_hit)   state_d = GUARD_OPEN;  // UNLOCK
            GUARD_OPEN: if (top_touch) state_d = GUARD_SHUT;  // RELOCK
            default:                   state_d = GUARD_SHUT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GUARD_SHUT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            GUARD_OPEN: unlocked = 1'b1;
            default:    unlocked = 1'b0;
        endcase
    end

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_hit && !unlocked) |=> unlocked); // R4
    AST_TOP_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (top_touch && unlocked) |=> !unlocked); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_hit && !top_touch) |=> $stable(unlocked)); // R5
endmodule

// File: rtl/vbg_base_reg.sv
module vbg_base_reg #(
    parameter int unsigned NLANES     = 4,
    parameter int unsigned ALIGN_BITS = 10,
    parameter logic [NLANES*8-1:0] RESET_BASE = 32'h00C0_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NLANES-1:0]     lane_we,
    input  logic [NLANES*8-1:0]   wdata,
    output logic [NLANES*8-1:0]   q
);
    localparam int unsigned        W         = NLANES * 8;
    localparam logic [W-1:0]       KEEP_MASK = ~((W'(1) << ALIGN_BITS) - W'(1));
    localparam logic [W-1:0]       RST_VAL   = RESET_BASE & KEEP_MASK;

    logic [W-1:0] store_q;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                store_q[g*8 +: 8] <= RST_VAL[g*8 +: 8];
            else if (lane_we[g])
                store_q[g*8 +: 8] <= wdata[g*8 +: 8] & KEEP_MASK[g*8 +: 8];
        end

        AST_LANE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_we[g] |=> $stable(q[g*8 +: 8])); // R10
    end

    assign q = store_q & KEEP_MASK;
endmodule

// File: rtl/vbase_guard.sv
module vbase_guard #(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned NLANES     = 4,
    parameter int unsigned PROT_IDX   = 0,
    parameter int unsigned BASE_IDX   = 1,
    parameter int unsigned KEY_LANE   = 1,
    parameter logic [7:0]  KEY        = 8'h59,
    parameter int unsigned ALIGN_BITS = 10,
    parameter logic [31:0] RESET_BASE = 32'h00C0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       vec_base
);
    logic       sel_base;
    logic       key_hit;
    logic       base_wr;
    logic       top_touch;
    logic       unlocked;
    logic [3:0] lane_we;

    vbg_decode #(
        .ADDR_W(ADDR_W), .NLANES(NLANES), .PROT_IDX(PROT_IDX),
        .BASE_IDX(BASE_IDX), .KEY_LANE(KEY_LANE), .KEY(KEY)
    ) u_dec (
        .addr(bus_addr), .wr(bus_wr), .be(bus_be), .wdata(bus_wdata),
        .sel_base(sel_base), .key_hit(key_hit),
        .base_wr(base_wr), .top_touch(top_touch)
    );

    vbg_lock_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .key_hit(key_hit),
        .top_touch(top_touch), .unlocked(unlocked)
    );

    assign lane_we = {NLANES{base_wr && unlocked}} & bus_be;

    vbg_base_reg #(
        .NLANES(NLANES), .ALIGN_BITS(ALIGN_BITS), .RESET_BASE(RESET_BASE)
    ) u_base (
        .clk(clk), .rst_n(rst_n), .lane_we(lane_we),
        .wdata(bus_wdata), .q(vec_base)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_base) bus_rdata = vec_base;
    end

    AST_SHUT_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_base && !unlocked) |=> $stable(vec_base)); // R3
    AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vec_base[ALIGN_BITS-1:0] == '0); // R2
    AST_OFF_MAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !sel_base) |=> $stable(vec_base)); // R11
    AST_PROT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(PROT_IDX)) |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/vbase_guard_test.sv
`timescale 1ns/1ps
module vbase_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] vec_base;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] ref_base;
    bit          ref_open;

    always #2 clk = ~clk;

    vbase_guard uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .vec_base(vec_base)
    );

    function automatic logic [31:0] merge_lanes(logic [31:0] old, logic [31:0] wd,
                                                logic [3:0] be);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++)
            if (be[i]) r[i*8 +: 8] = wd[i*8 +: 8];
        return r & 32'hFFFF_FC00;
    endfunction

    task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic read_chk(logic [3:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        #1;
        compare(tag, bus_rdata, exp);
    endtask

    task automatic write_op(logic [3:0] a, logic [3:0] be, logic [31:0] d, string tag);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        // reference model
        if (a == 4'd1 && ref_open) begin
            ref_base = merge_lanes(ref_base, d, be);
            if (be[3]) ref_open = 1'b0;
        end else if (a == 4'd0 && be[1] && d[15:8] == 8'h59) begin
            ref_open = 1'b1;
        end
        compare(tag, vec_base, ref_base);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        ref_base = 32'h00C0_0000;
        ref_open = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset value and read
        compare("R1 reset output", vec_base, 32'h00C0_0000);
        read_chk(4'd1, 32'h00C0_0000, "R1 reset read");
        // R3 locked after reset
        write_op(4'd1, 4'b0011, 32'h0000_5555, "R3 shut low write");
        write_op(4'd1, 4'b1111, 32'hAAAA_AAAA, "R3 shut word write");
        // R5 wrong key stays shut
        write_op(4'd0, 4'b0010, 32'h0000_5800, "R5 bad key");
        write_op(4'd1, 4'b1111, 32'h1234_5678, "R5 still shut");
        write_op(4'd0, 4'b0001, 32'h0000_5959, "R5 key without lane1");
        write_op(4'd1, 4'b0011, 32'h0000_FFFF, "R5 still shut after lane0");
        // R4 unlock, R6 low half keeps open, R2 alignment
        write_op(4'd0, 4'b0010, 32'h0000_5900, "R4 unlock");
        write_op(4'd1, 4'b0011, 32'h0000_FFFF, "R6 low half R2 low bits zero");
        read_chk(4'd1, 32'h00C0_FC00, "R2 read aligned");
        // R5 bad key while open keeps it open
        write_op(4'd0, 4'b0010, 32'h0000_1200, "R5 bad key while open");
        // R7 high half relocks
        write_op(4'd1, 4'b1100, 32'h8765_0000, "R7 high half");
        write_op(4'd1, 4'b0011, 32'h0000_0400, "R7 locked after high");
        // R10 lane 2 only, open stays
        write_op(4'd0, 4'b0010, 32'h0000_5900, "R4 unlock again");
        write_op(4'd1, 4'b0100, 32'h00EE_0000, "R10 lane2 only");
        write_op(4'd1, 4'b1000, 32'h3300_0000, "R10 lane3 only relocks R7");
        // R8 word write relocks
        write_op(4'd0, 4'b1111, 32'h0000_5900, "R4 word-wide key");
        write_op(4'd1, 4'b1111, 32'hDEAD_BEEF, "R8 word write");
        write_op(4'd1, 4'b1111, 32'h0000_0000, "R8 relocked");
        // R9 reads in both states, protect reads zero
        read_chk(4'd0, 32'h0, "R9 protect reads zero");
        read_chk(4'd1, 32'hDEAD_BC00, "R9 read while shut");
        write_op(4'd0, 4'b0010, 32'h0000_5900, "R4 unlock for read");
        read_chk(4'd1, 32'hDEAD_BC00, "R9 read while open");
        read_chk(4'd0, 32'h0, "R9 protect reads zero open");
        // R11 off-map
        write_op(4'd5, 4'b1111, 32'hFFFF_FFFF, "R11 off-map write");
        read_chk(4'd5, 32'h0, "R11 off-map read");
        write_op(4'd1, 4'b0011, 32'h0000_1C00, "R11 still open");

        // random phase
        for (int k = 0; k < 600; k++) begin
            logic [3:0]  a;
            logic [3:0]  be;
            logic [31:0] d;
            int          sel = $urandom % 8;
            a  = (sel < 3) ? 4'd0 : (sel < 7) ? 4'd1 : 4'($urandom);
            be = 4'($urandom);
            d  = $urandom;
            if (a == 4'd0 && ($urandom % 2) == 0) d[15:8] = 8'h59;
            write_op(a, be, d, "R10 random access");
            read_chk(4'd1, ref_base, "R9 random base read");
            read_chk(4'd0, 32'h0, "R9 random protect read");
            if (a > 4'd1) read_chk(a, 32'h0, "R11 random off-map read");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule